// File: doc/BRIEF.md
# Utilization-Driven Datapath Gating Controller

This block watches one GPU core pipeline over fixed-length epochs and decides which half-width slices of that pipeline may be switched off. It counts busy cycles for each datapath component: the fetch/decode front end, the wavefront scheduler, and one register-bank group and one operand pipeline register for each of the three execute paths. It also derives busy time for the SP and SFU execute units from their issue strobes, because those units have a fixed service time. For the LD/ST path it counts request arrivals and accumulates the number of outstanding requests. From these counts it judges whether the memory system is slow to respond, with no divider.

At every epoch boundary the counts are frozen and every output returns to full width. A sequencer then steps through three phases in a fixed order. The first phase handles the execute units. The second handles the register groups and pipeline registers, each against its own execute unit. The third handles the issue width and the fetch/decode width. One cycle after the third phase, the new enables are driven from registers. Only the two arithmetic execute units have power-gate enables. Every unit that holds data gets a clock-gate enable only. When a power gate is released, a per-unit ready flag stays low for a fixed wake-up time.

The epoch must be longer than the five-cycle decision sequence.

Top module: `dpgate_ctrl`

## Requirements
- R1: While reset is held, and after it until the first epoch's decisions are applied, `pg_o`, `cg_o` and `half_issue_o` are all zero and both bits of `ready_o` are one.
- R2: An epoch lasts EPOCH clock cycles. On the cycle after an epoch boundary all enables fall to zero and `half_issue_o` clears. They hold at zero for exactly four cycles, and then the decisions from that epoch appear. This gives one update every EPOCH cycles.
- R3: Busy time for SP (pg_o bit 0) and SFU (pg_o bit 1) equals the issue count times SP_SVC or SFU_SVC. A unit is power-gated when busy*256 < UTIL_THR_Q8*EPOCH. A unit exactly at the limit stays on.
- R4: The LD/ST execute unit is clock-gated (cg_o bit 7) when the occupancy sum exceeds RT_THR times the arrival count. The occupancy sum is the per-cycle `ls_occ_i` summed over the epoch. Equality does not gate. An epoch with no arrivals never gates the unit.
- R5: The register group (cg_o bits 1,2,3 for SP,SFU,LD/ST) and pipeline register (cg_o bits 4,5,6 for SP,SFU,LD/ST) of an execute path are clock-gated when their busy count is strictly below that path's execute busy time. Equal counts do not gate. The execute busy time for LD/ST is busy_i bit 8.
- R6: `half_issue_o` is set when the scheduler busy count (busy_i bit 1) is strictly below the sum of the SP, SFU and LD/ST execute busy times.
- R7: Fetch/decode is clock-gated (cg_o bit 0) only when `half_issue_o` is set for the same epoch and the fetch/decode busy count (busy_i bit 0) is strictly below the scheduler busy count.
- R8: A unit's ready flag is low whenever its power gate is asserted. After a power gate deasserts, the flag stays low for WAKE cycles and then rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy_i | input | 9 | Per-cycle busy: 0 fetch/decode, 1 scheduler, 2-4 register groups SP/SFU/LD-ST, 5-7 pipeline registers SP/SFU/LD-ST, 8 LD/ST execute |
| sp_issue_i | input | 1 | One SP instruction issued this cycle |
| sfu_issue_i | input | 1 | One SFU instruction issued this cycle |
| ls_arrive_i | input | 1 | One LD/ST request arrived this cycle |
| ls_occ_i | input | OCC_W | LD/ST requests outstanding this cycle |
| pg_o | output | 2 | Power-gate enables: 0 SP, 1 SFU |
| ready_o | output | 2 | Unit ready after wake-up: 0 SP, 1 SFU |
| cg_o | output | 8 | Clock-gate enables, bit map as in R4, R5, R7 |
| half_issue_o | output | 1 | Scheduler runs at half issue width |

## Verification
The hardest states to reach are the ready-flag wake-up and the four-cycle revert window. The epoch-boundary revert releases every power gate, and a unit that stays idle is gated again only four cycles later. With a wake-up longer than four cycles, a ready rise is therefore seen only after the unit becomes busy. The bench first drives an idle SP unit so that its gate is reasserted every epoch. It measures the revert window and the epoch period from the pg edges, then raises SP activity and times the ready rise from the last gate release. All stimulus is periodic with a period that divides the epoch, so each epoch's counts, and with them every threshold boundary case, are known exactly regardless of phase.

// File: rtl/dgc_pkg.sv
// Shared indices and the decision sequencer state for the gating controller.
package dgc_pkg;
    localparam int NBUSY  = 9;
    localparam int NPATH  = 3;   // execute paths: SP, SFU, LD/ST
    localparam int NCG    = 8;
    localparam int NPG    = 2;
    // busy_i positions
    localparam int B_FD   = 0;
    localparam int B_SCH  = 1;
    localparam int B_RF0  = 2;   // register groups SP, SFU, LD/ST
    localparam int B_PR0  = 5;   // pipeline registers SP, SFU, LD/ST
    localparam int B_EXLS = 8;
    // cg_o positions
    localparam int CG_FD   = 0;
    localparam int CG_RF0  = 1;
    localparam int CG_PR0  = 4;
    localparam int CG_EXLS = 7;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_P1,
        SEQ_P2,
        SEQ_P3,
        SEQ_APPLY
    } seq_t;
endpackage

// File: rtl/dgc_activity.sv
// Epoch timer and activity accumulators.
// Counts busy cycles per component, converts SP/SFU issues to busy time with a
// fixed service time, counts LD/ST arrivals and sums LD/ST occupancy. On the
// last cycle of an epoch every accumulator is copied (including that cycle's
// sample) into a snapshot and cleared. Assumes EPOCH >= 2.
module dgc_activity
    import dgc_pkg::*;
#(
    parameter int EPOCH   = 1024,
    parameter int SP_SVC  = 2,
    parameter int SFU_SVC = 4,
    parameter int OCC_W   = 6,
    parameter int UW      = 13,
    parameter int OSW     = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBUSY-1:0] busy_i,
    input  logic             sp_issue_i,
    input  logic             sfu_issue_i,
    input  logic             ls_arrive_i,
    input  logic [OCC_W-1:0] ls_occ_i,
    output logic             snap_vld_o,
    output logic [UW-1:0]    snap_busy_o [NBUSY],
    output logic [UW-1:0]    snap_sp_o,
    output logic [UW-1:0]    snap_sfu_o,
    output logic [UW-1:0]    snap_arr_o,
    output logic [OSW-1:0]   snap_occ_o
);
    localparam int EW = (EPOCH > 2) ? $clog2(EPOCH) : 1;

    logic [EW-1:0] ecnt;
    logic          last;

    assign last = (ecnt == EW'(EPOCH - 1));

    // Epoch position counter, wraps at EPOCH.
    always_ff @(posedge clk) begin
        if (!rst_n)    ecnt <= '0;
        else if (last) ecnt <= '0;
        else           ecnt <= ecnt + 1'b1;
    end

    // One-cycle flag telling the sequencer a fresh snapshot is present.
    always_ff @(posedge clk) begin
        if (!rst_n) snap_vld_o <= 1'b0;
        else        snap_vld_o <= last;
    end

    genvar g;
    generate
        for (g = 0; g < NBUSY; g++) begin : g_busy
            logic [UW-1:0] acc;
            logic [UW-1:0] nxt;
            assign nxt = acc + UW'(busy_i[g]);
            // Busy-cycle accumulator with snapshot at the epoch end.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    acc            <= '0;
                    snap_busy_o[g] <= '0;
                end else if (last) begin
                    acc            <= '0;
                    snap_busy_o[g] <= nxt;
                end else begin
                    acc <= nxt;
                end
            end
        end
    endgenerate

    logic [UW-1:0]  sp_acc, sfu_acc, arr_acc;
    logic [UW-1:0]  sp_nxt, sfu_nxt, arr_nxt;
    logic [OSW-1:0] occ_acc, occ_nxt;

    assign sp_nxt  = sp_acc  + (sp_issue_i  ? UW'(SP_SVC)  : '0);
    assign sfu_nxt = sfu_acc + (sfu_issue_i ? UW'(SFU_SVC) : '0);
    assign arr_nxt = arr_acc + UW'(ls_arrive_i);
    assign occ_nxt = occ_acc + OSW'(ls_occ_i);

    // Service-time busy, arrival and occupancy accumulators.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_acc  <= '0; sfu_acc <= '0; arr_acc <= '0; occ_acc <= '0;
            snap_sp_o <= '0; snap_sfu_o <= '0; snap_arr_o <= '0; snap_occ_o <= '0;
        end else if (last) begin
            sp_acc  <= '0; sfu_acc <= '0; arr_acc <= '0; occ_acc <= '0;
            snap_sp_o  <= sp_nxt;
            snap_sfu_o <= sfu_nxt;
            snap_arr_o <= arr_nxt;
            snap_occ_o <= occ_nxt;
        end else begin
            sp_acc  <= sp_nxt;
            sfu_acc <= sfu_nxt;
            arr_acc <= arr_nxt;
            occ_acc <= occ_nxt;
        end
    end

    // R2
    epoch_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ecnt <= EW'(EPOCH - 1));
    // R2
    snap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_vld_o |=> !snap_vld_o);
endmodule

// File: rtl/dgc_decide.sv
// Three-phase decision sequencer and output registers.
// On a new snapshot all outputs revert to full width. Phase 1 judges the
// execute units, phase 2 each register group and pipeline register against
// its execute unit, phase 3 the issue width and then fetch/decode. The
// decisions are driven out on the cycle after phase 3.
// Assumes snapshots arrive at least five cycles apart.
module dgc_decide
    import dgc_pkg::*;
#(
    parameter int EPOCH       = 1024,
    parameter int UTIL_THR_Q8 = 64,
    parameter int RT_THR      = 200,
    parameter int UW          = 13,
    parameter int OSW         = 17
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           snap_vld_i,
    input  logic [UW-1:0]  snap_busy_i [NBUSY],
    input  logic [UW-1:0]  snap_sp_i,
    input  logic [UW-1:0]  snap_sfu_i,
    input  logic [UW-1:0]  snap_arr_i,
    input  logic [OSW-1:0] snap_occ_i,
    output logic [NPG-1:0] pg_o,
    output logic [NCG-1:0] cg_o,
    output logic           half_o
);
    localparam int PW = UW + OSW + 34;
    localparam logic [PW-1:0] LOW_LIM = PW'(UTIL_THR_Q8) * PW'(EPOCH);

    seq_t             state;
    logic [NPG-1:0]   d_pg;
    logic             d_ls;
    logic [NPATH-1:0] d_rf, d_pr;
    logic             d_half, d_fd;
    logic [UW-1:0]    ex_busy [NPATH];
    logic [UW+1:0]    ex_sum;
    logic             half_n;

    assign ex_busy[0] = snap_sp_i;
    assign ex_busy[1] = snap_sfu_i;
    assign ex_busy[2] = snap_busy_i[B_EXLS];
    assign ex_sum = (UW+2)'(ex_busy[0]) + (UW+2)'(ex_busy[1]) + (UW+2)'(ex_busy[2]);
    assign half_n = ((UW+2)'(snap_busy_i[B_SCH]) < ex_sum);

    // Phase sequencer, decision registers and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SEQ_IDLE;
            pg_o   <= '0;
            cg_o   <= '0;
            half_o <= 1'b0;
            d_pg   <= '0;
            d_ls   <= 1'b0;
            d_rf   <= '0;
            d_pr   <= '0;
            d_half <= 1'b0;
            d_fd   <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (snap_vld_i) begin
                        state  <= SEQ_P1;
                        pg_o   <= '0;
                        cg_o   <= '0;
                        half_o <= 1'b0;
                    end
                end
                SEQ_P1: begin
                    d_pg[0] <= ((PW'(snap_sp_i)  << 8) < LOW_LIM);
                    d_pg[1] <= ((PW'(snap_sfu_i) << 8) < LOW_LIM);
                    d_ls    <= (snap_arr_i != '0) &&
                               (PW'(snap_occ_i) > PW'(snap_arr_i) * PW'(RT_THR));
                    state   <= SEQ_P2;
                end
                SEQ_P2: begin
                    for (int u = 0; u < NPATH; u++) begin
                        d_rf[u] <= (snap_busy_i[B_RF0 + u] < ex_busy[u]);
                        d_pr[u] <= (snap_busy_i[B_PR0 + u] < ex_busy[u]);
                    end
                    state <= SEQ_P3;
                end
                SEQ_P3: begin
                    d_half <= half_n;
                    d_fd   <= half_n && (snap_busy_i[B_FD] < snap_busy_i[B_SCH]);
                    state  <= SEQ_APPLY;
                end
                SEQ_APPLY: begin
                    pg_o   <= d_pg;
                    cg_o   <= {d_ls, d_pr, d_rf, d_fd};
                    half_o <= d_half;
                    state  <= SEQ_IDLE;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // R2
    revert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SEQ_IDLE) |-> (pg_o == '0 && cg_o == '0 && !half_o));
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE && $past(state) == SEQ_IDLE) |-> $stable({pg_o, cg_o, half_o}));
    // R7
    fd_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cg_o[CG_FD] |-> half_o);
endmodule

// File: rtl/dgc_wake_timer.sv
// Wake-up timer for one power-gated unit. While the gate is asserted the
// timer is held at WAKE; after release it counts down and the unit is
// reported ready once it reaches zero. Assumes WAKE >= 1.
module dgc_wake_timer #(
    parameter int WAKE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pg_i,
    output logic ready_o
);
    localparam int TW = $clog2(WAKE + 1);

    logic [TW-1:0] cnt;

    // Load while gated, count down after release.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (pg_i)       cnt <= TW'(WAKE);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign ready_o = !pg_i && (cnt == '0);

    // R8
    gated_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_i |-> !ready_o);
    // R8
    release_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pg_i) |-> !ready_o);
endmodule

// File: rtl/dpgate_ctrl.sv
// Top of the utilization-driven datapath gating controller: activity
// accumulation, three-phase decisions and per-unit wake-up timers.
// Assumes EPOCH > 5 so a decision sequence ends before the next snapshot.
module dpgate_ctrl
    import dgc_pkg::*;
#(
    parameter int EPOCH       = 1024,
    parameter int SP_SVC      = 2,
    parameter int SFU_SVC     = 4,
    parameter int OCC_W       = 6,
    parameter int UTIL_THR_Q8 = 64,
    parameter int RT_THR      = 200,
    parameter int WAKE        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [8:0]       busy_i,
    input  logic             sp_issue_i,
    input  logic             sfu_issue_i,
    input  logic             ls_arrive_i,
    input  logic [OCC_W-1:0] ls_occ_i,
    output logic [1:0]       pg_o,
    output logic [1:0]       ready_o,
    output logic [7:0]       cg_o,
    output logic             half_issue_o
);
    localparam int MAXSVC = (SP_SVC > SFU_SVC) ? ((SP_SVC > 1) ? SP_SVC : 1)
                                               : ((SFU_SVC > 1) ? SFU_SVC : 1);
    localparam int UW  = $clog2(EPOCH * MAXSVC + 1);
    localparam int OSW = OCC_W + $clog2(EPOCH + 1);

    logic           snap_vld;
    logic [UW-1:0]  snap_busy [NBUSY];
    logic [UW-1:0]  snap_sp, snap_sfu, snap_arr;
    logic [OSW-1:0] snap_occ;

    dgc_activity #(
        .EPOCH(EPOCH), .SP_SVC(SP_SVC), .SFU_SVC(SFU_SVC),
        .OCC_W(OCC_W), .UW(UW), .OSW(OSW)
    ) u_activity (
        .clk(clk), .rst_n(rst_n),
        .busy_i(busy_i), .sp_issue_i(sp_issue_i), .sfu_issue_i(sfu_issue_i),
        .ls_arrive_i(ls_arrive_i), .ls_occ_i(ls_occ_i),
        .snap_vld_o(snap_vld), .snap_busy_o(snap_busy),
        .snap_sp_o(snap_sp), .snap_sfu_o(snap_sfu),
        .snap_arr_o(snap_arr), .snap_occ_o(snap_occ)
    );

    dgc_decide #(
        .EPOCH(EPOCH), .UTIL_THR_Q8(UTIL_THR_Q8), .RT_THR(RT_THR),
        .UW(UW), .OSW(OSW)
    ) u_decide (
        .clk(clk), .rst_n(rst_n),
        .snap_vld_i(snap_vld), .snap_busy_i(snap_busy),
        .snap_sp_i(snap_sp), .snap_sfu_i(snap_sfu),
        .snap_arr_i(snap_arr), .snap_occ_i(snap_occ),
        .pg_o(pg_o), .cg_o(cg_o), .half_o(half_issue_o)
    );

    genvar w;
    generate
        for (w = 0; w < NPG; w++) begin : g_wake
            dgc_wake_timer #(.WAKE(WAKE)) u_wake (
                .clk(clk), .rst_n(rst_n),
                .pg_i(pg_o[w]), .ready_o(ready_o[w])
            );
        end
    endgenerate
endmodule

// File: tb/dpgate_ctrl_bench.sv
`timescale 1ns/100ps
module dpgate_ctrl_bench;
    localparam int EP   = 64;
    localparam int WK   = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] busy_i = '0;
    logic       sp_issue_i = 1'b0, sfu_issue_i = 1'b0, ls_arrive_i = 1'b0;
    logic [5:0] ls_occ_i = '0;
    logic [1:0] pg_o, ready_o;
    logic [7:0] cg_o;
    logic       half_issue_o;

    int total = 0, bad = 0, cyc = 0, ph = 0;
    int d_busy [9];
    int d_sp = 0, d_sfu = 0, d_arr = 0, occ_v = 0;

    dpgate_ctrl #(
        .EPOCH(EP), .SP_SVC(2), .SFU_SVC(4), .OCC_W(6),
        .UTIL_THR_Q8(64), .RT_THR(4), .WAKE(WK)
    ) u_dpgate_ctrl (
        .clk(clk), .rst_n(rst_n), .busy_i(busy_i),
        .sp_issue_i(sp_issue_i), .sfu_issue_i(sfu_issue_i),
        .ls_arrive_i(ls_arrive_i), .ls_occ_i(ls_occ_i),
        .pg_o(pg_o), .ready_o(ready_o), .cg_o(cg_o), .half_issue_o(half_issue_o)
    );

    always #2.5 clk = ~clk;

    // Periodic stimulus, period 8, driven at the falling edge.
    initial begin
        for (int i = 0; i < 9; i++) d_busy[i] = 0;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % 8;
            for (int i = 0; i < 9; i++) busy_i[i] = (ph < d_busy[i]);
            sp_issue_i  = (ph < d_sp);
            sfu_issue_i = (ph < d_sfu);
            ls_arrive_i = (ph < d_arr);
            ls_occ_i    = 6'(occ_v);
        end
    end

    initial forever begin
        @(posedge clk);
        if (rst_n) cyc = cyc + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_pat();
        for (int i = 0; i < 9; i++) d_busy[i] = 0;
        d_sp = 0; d_sfu = 0; d_arr = 0; occ_v = 0;
    endtask

    // Let two full epochs pass, then sample mid-epoch, away from the revert.
    task automatic settle();
        repeat (2 * EP + 8) @(posedge clk);
        while (cyc % EP != 32) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 pg in reset", 32'(pg_o), 0);
        chk("R1 cg in reset", 32'(cg_o), 0);
        chk("R1 half in reset", 32'(half_issue_o), 0);
        chk("R1 ready in reset", 32'(ready_o), 3);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R1 full width before first decision", 32'({pg_o, cg_o, half_issue_o}), 0);
        chk("R1 ready before first decision", 32'(ready_o), 3);
    endtask

    task automatic t_idle();
        clear_pat();
        settle();
        chk("R3 idle SP/SFU power gated", 32'(pg_o), 3);
        chk("R4 R5 idle no clock gates", 32'(cg_o), 0);
        chk("R6 idle full issue", 32'(half_issue_o), 0);
        chk("R8 gated units not ready", 32'(ready_o), 0);
    endtask

    task automatic t_compute();
        clear_pat();
        d_sp = 4; d_sfu = 1; d_busy[8] = 2;
        d_busy[2] = 8; d_busy[5] = 2;   // SP path: equal, lower
        d_busy[3] = 1; d_busy[6] = 4;   // SFU path: lower, equal
        d_busy[4] = 1; d_busy[7] = 0;   // LD/ST path: both lower
        d_busy[1] = 8; d_busy[0] = 4;   // scheduler 64 < 112, fd 32 < 64
        settle();
        chk("R3 busy units stay powered", 32'(pg_o), 0);
        chk("R5 R7 compute clock gates", 32'(cg_o), 32'h5D);
        chk("R6 compute half issue", 32'(half_issue_o), 1);
        chk("R8 powered units ready", 32'(ready_o), 3);
    endtask

    task automatic t_sp_edge();
        clear_pat();
        d_sp = 1;                        // 8 issues * 2 = 16 = limit
        settle();
        chk("R3 SP at limit stays on, SFU idle gated", 32'(pg_o), 2);
    endtask

    task automatic t_memory();
        clear_pat();
        d_arr = 1; occ_v = 8;            // 512 > 4*8
        d_busy[8] = 8; d_busy[1] = 8;    // scheduler 64 = ex sum 64
        d_busy[0] = 2;
        settle();
        chk("R4 slow memory gates LD/ST, R5 LD/ST path", 32'(cg_o), 32'hC8);
        chk("R6 equal scheduler keeps full issue", 32'(half_issue_o), 0);
        chk("R7 fd stays full without half issue", 32'(cg_o[0]), 0);
    endtask

    task automatic t_rt_edge();
        clear_pat();
        d_arr = 8; occ_v = 4;            // 256 = 4*64
        settle();
        chk("R4 response at threshold no gate", 32'(cg_o[7]), 0);
        occ_v = 5;                       // 320 > 256
        settle();
        chk("R4 response over threshold gates", 32'(cg_o[7]), 1);
        d_arr = 0;
        settle();
        chk("R4 zero arrivals no gate", 32'(cg_o[7]), 0);
    endtask

    task automatic t_timing();
        int n;
        logic prev;
        clear_pat();
        settle();
        // find a release of the SP gate
        prev = pg_o[0];
        forever begin
            @(negedge clk);
            if (prev && !pg_o[0]) break;
            prev = pg_o[0];
        end
        n = 0;
        while (!pg_o[0]) begin
            n++;
            @(negedge clk);
        end
        chk("R2 revert window length", 32'(n), 4);
        n = 0;
        prev = pg_o[0];
        forever begin
            @(negedge clk);
            n++;
            if (!prev && pg_o[0]) break;
            prev = pg_o[0];
        end
        chk("R2 decision period", 32'(n), EP);
        // make SP busy and time the ready rise after the final release
        d_sp = 4;
        n = 0;
        for (int k = 0; k < 4 * EP; k++) begin
            @(negedge clk);
            if (pg_o[0]) n = 0;
            else if (!ready_o[0]) n++;
            else break;
        end
        chk("R8 wake delay", 32'(n), WK);
        chk("R8 ready after wake", 32'(ready_o[0]), 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_idle();
                t_compute();
                t_sp_edge();
                t_memory();
                t_rt_edge();
                t_timing();
            end
            begin
                repeat (100000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired actual=hung expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule